// File: doc/BRIEF.md
# Priority Interrupt and Trap Entry Sequencer

This block sits beside an instruction sequencer. At every instruction boundary, and on every cycle while the processor waits for an interrupt, it decides whether a trap or an interrupt has to be taken. If one is due, it runs the vectored entry on a simple word-wide memory port. The sequence fetches the new status word from the vector, saves the interrupted status word and program counter on the stack, and fetches the new program counter. When the sequence finishes, it presents the new PC, PSW and stack pointer.

Interrupts come from two places. The first is a software request register, which holds one bit per priority level. The second is a set of per-level bus sources, and each of these supplies its own vector. Both kinds go through one scan from the highest level downward. Bus faults and illegal opcodes are synchronous traps and rank above any interrupt. A granted bus source gets a one-cycle acknowledge pulse. The error-register bits for a bus fault come out as a one-cycle set mask. A waiting processor gets a resume pulse when an interrupt wakes it.

Top module: `irq_trap_seq`

## Requirements
- R1: For the first cycle after synchronous reset is released, no memory request is driven, and entry_done, resume, fetch_go, every bus_irq_ack bit and every err_set bit are low.
- R2: Only a level strictly above psw_pri can be granted. When several levels are eligible, the highest one wins. A request at or below psw_pri causes no memory access.
- R3: Level i (1..7) has its software request at bit 8+i of pir_reg. Within a level, the software request wins over the bus request. A software grant uses vector 0x00A0 and raises no acknowledge.
- R4: A granted bus request at level i uses that level's vector from bus_irq_vec, bits [(i-1)*16 +: 16]. A single-cycle pulse appears on bus_irq_ack[i] in the cycle after the grant, and no other acknowledge bit is high.
- R5: The entry performs four accesses in this order: read vector+2 (new PSW), write old PSW to SP-2, write old PC to SP-4, read vector (new PC). A one-cycle entry_done then shows new_pc, new_psw and new_sp = SP-4.
- R6: A non-existent-memory flag sets err_set bit 5, and a bus-timeout flag sets err_set bit 4. Either one traps through vector 0x0004. This trap ranks above illegal opcodes and interrupts, and err_set is a one-cycle pulse in the cycle after the boundary.
- R7: An illegal-opcode flag traps through vector 0x0010. It ranks above any pending interrupt and below a bus fault.
- R8: While cpu_waiting is high, a grantable interrupt starts the entry and pulses resume in the next cycle. With no grantable interrupt, nothing is fetched and fetch_go stays low. Fault and illegal-opcode flags are not acted on while waiting.
- R9: One boundary grants at most one event. A boundary that has nothing to take pulses fetch_go one cycle later. After entry_done, no new entry starts until the next boundary or wait cycle.
- R10: Once mem_req is raised, mem_addr, mem_we and mem_wdata hold steady until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_boundary | input | 1 | Processor is ready to fetch the next instruction |
| cpu_waiting | input | 1 | Processor is idle waiting for an interrupt |
| psw_pri | input | 3 | Current processor priority |
| pir_reg | input | 16 | Software interrupt request register (level i at bit 8+i) |
| bus_irq_req | input | 7 | Bus interrupt request, bit i-1 = level i |
| bus_irq_vec | input | 112 | Vector per bus level, 16 bits each, level 1 lowest |
| nxm_err | input | 1 | Non-existent memory fault in the last instruction |
| tmo_err | input | 1 | Bus timeout fault in the last instruction |
| bad_opcode | input | 1 | Illegal or reserved opcode in the last instruction |
| cur_pc | input | 16 | PC to save |
| cur_psw | input | 16 | PSW to save |
| cur_sp | input | 16 | Stack pointer before entry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| bus_irq_ack | output | 7 | One-cycle grant acknowledge per bus level |
| err_set | output | 16 | One-cycle mask of error-register bits to set |
| resume | output | 1 | One-cycle wake from the wait state |
| fetch_go | output | 1 | One-cycle permission to fetch the next instruction |
| entry_done | output | 1 | Entry complete, new state valid |
| new_pc | output | 16 | PC loaded from the vector |
| new_psw | output | 16 | PSW loaded from vector+2 |
| new_sp | output | 16 | Stack pointer after the two pushes |

## Verification
A wrong grant decision shows one cycle after the boundary. It appears as an acknowledge on the wrong bit, a missing or stray fetch_go, or an unexpected error mask, and it shows on the first memory address, which names the vector. A corrupted captured vector, saved context or stack pointer shows up in the address or data of one of the four accesses, each compared in order as it completes. A sequencer that skips, repeats or reorders a step shows at the next access or at entry_done. A sequencer that fails to return to idle shows as an access with no boundary before it.

// File: rtl/irq_seq_pkg.sv
// Shared constants and types for the interrupt/trap entry sequencer.
// Assumes 16-bit words with byte addressing (two bytes per word).
package irq_seq_pkg;
    localparam logic [15:0] VEC_PROG_IRQ   = 16'h00A0;
    localparam logic [15:0] VEC_BUS_FAULT  = 16'h0004;
    localparam logic [15:0] VEC_BAD_OPCODE = 16'h0010;
    localparam int ERR_NXM_POS    = 5;
    localparam int ERR_TMO_POS    = 4;
    localparam int PIR_LEVEL_BASE = 8;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_BUS_FAULT,
        EV_BAD_OP,
        EV_PROG_IRQ,
        EV_BUS_IRQ
    } event_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GET_PSW,
        SQ_PUSH_PSW,
        SQ_PUSH_PC,
        SQ_GET_PC
    } seq_state_e;
endpackage

// File: rtl/irq_level_scan.sv
// Combinational priority scan over levels 1..NLEV-1.
// A level is eligible only when it is strictly above the current priority.
// The highest eligible level wins. Within a level, the software request
// wins over the bus request.
module irq_level_scan
    import irq_seq_pkg::*;
#(
    parameter int NLEV = 8,
    parameter int DW   = 16,
    localparam int LW  = $clog2(NLEV)
) (
    input  logic [LW-1:0]            pri,
    input  logic [NLEV-1:1]          sw_req,
    input  logic [NLEV-1:1]          hw_req,
    input  logic [(NLEV-1)*DW-1:0]   hw_vec,
    output logic                     hit,
    output logic                     from_bus,
    output logic [LW-1:0]            level,
    output logic [DW-1:0]            vector
);
    logic [NLEV-1:1] sw_ok;
    logic [NLEV-1:1] hw_ok;

    // Per-level eligibility against the current priority.
    for (genvar l = 1; l < NLEV; l++) begin : g_lvl
        assign sw_ok[l] = sw_req[l] && (LW'(l) > pri);
        assign hw_ok[l] = hw_req[l] && (LW'(l) > pri);
    end

    // Ascending walk: the last hit found (the highest level) wins.
    always_comb begin
        hit      = 1'b0;
        from_bus = 1'b0;
        level    = '0;
        vector   = '0;
        for (int l = 1; l < NLEV; l++) begin
            if (sw_ok[l]) begin
                hit      = 1'b1;
                from_bus = 1'b0;
                level    = LW'(l);
                vector   = DW'(VEC_PROG_IRQ);
            end else if (hw_ok[l]) begin
                hit      = 1'b1;
                from_bus = 1'b1;
                level    = LW'(l);
                vector   = hw_vec[(l-1)*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/trap_priority_pick.sv
// Chooses the event for this cycle: bus fault, then illegal opcode, then
// interrupt. Evaluation happens only when the sequencer is idle.
// Assumes the trap flags are only meaningful at an instruction boundary.
// While waiting, only interrupts are considered.
module trap_priority_pick
    import irq_seq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          idle,
    input  logic          boundary,
    input  logic          waiting,
    input  logic          nxm_err,
    input  logic          tmo_err,
    input  logic          bad_opcode,
    input  logic          irq_hit,
    input  logic          irq_from_bus,
    input  logic [DW-1:0] irq_vec,
    output event_e        kind,
    output logic [DW-1:0] vector,
    output logic          take,
    output logic          fetch_ok
);
    // Fixed ranking of synchronous traps over interrupts.
    always_comb begin
        kind   = EV_NONE;
        vector = '0;
        if (idle) begin
            if (waiting) begin
                if (irq_hit) begin
                    kind   = irq_from_bus ? EV_BUS_IRQ : EV_PROG_IRQ;
                    vector = irq_vec;
                end
            end else if (boundary) begin
                if (nxm_err || tmo_err) begin
                    kind   = EV_BUS_FAULT;
                    vector = DW'(VEC_BUS_FAULT);
                end else if (bad_opcode) begin
                    kind   = EV_BAD_OP;
                    vector = DW'(VEC_BAD_OPCODE);
                end else if (irq_hit) begin
                    kind   = irq_from_bus ? EV_BUS_IRQ : EV_PROG_IRQ;
                    vector = irq_vec;
                end
            end
        end
    end

    assign take     = (kind != EV_NONE);
    assign fetch_ok = idle && boundary && !waiting && !take;
endmodule

// File: rtl/vector_entry_seq.sv
// Runs the four-step vectored entry on a request/acknowledge memory port:
// read the new PSW at vector+2, push the old PSW, push the old PC, read the
// new PC at the vector. The context is captured on start. Each push
// pre-decrements the stack by one word.
// Assumes the memory holds its acknowledge high for a single cycle.
module vector_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] vec,
    input  logic [DW-1:0] cur_pc,
    input  logic [DW-1:0] cur_psw,
    input  logic [DW-1:0] cur_sp,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          idle,
    output logic          done,
    output logic [DW-1:0] new_pc,
    output logic [DW-1:0] new_psw,
    output logic [DW-1:0] new_sp
);
    localparam int WB = DW / 8;

    seq_state_e    st;
    logic [DW-1:0] vec_q, psw_q, pc_q, sp_q;
    logic [DW-1:0] npc_q, npsw_q, nsp_q;
    logic          done_q;

    // Step sequencing, result capture and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SQ_IDLE;
            vec_q  <= '0;
            psw_q  <= '0;
            pc_q   <= '0;
            sp_q   <= '0;
            npc_q  <= '0;
            npsw_q <= '0;
            nsp_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                SQ_IDLE: if (start) begin
                    st    <= SQ_GET_PSW;
                    vec_q <= vec;
                    psw_q <= cur_psw;
                    pc_q  <= cur_pc;
                    sp_q  <= cur_sp;
                end
                SQ_GET_PSW: if (mem_ack) begin
                    npsw_q <= mem_rdata;
                    st     <= SQ_PUSH_PSW;
                end
                SQ_PUSH_PSW: if (mem_ack) st <= SQ_PUSH_PC;
                SQ_PUSH_PC:  if (mem_ack) st <= SQ_GET_PC;
                SQ_GET_PC: if (mem_ack) begin
                    npc_q  <= mem_rdata;
                    nsp_q  <= sp_q - DW'(2 * WB);
                    done_q <= 1'b1;
                    st     <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Memory port drive for the current step.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            SQ_GET_PSW:  mem_addr = vec_q + DW'(WB);
            SQ_PUSH_PSW: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q - DW'(WB);
                mem_wdata = psw_q;
            end
            SQ_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q - DW'(2 * WB);
                mem_wdata = pc_q;
            end
            SQ_GET_PC:   mem_addr = vec_q;
            default:     mem_req = 1'b0;
        endcase
    end

    assign idle    = (st == SQ_IDLE);
    assign done    = done_q;
    assign new_pc  = npc_q;
    assign new_psw = npsw_q;
    assign new_sp  = nsp_q;
endmodule

// File: rtl/irq_trap_seq.sv
// Top of the interrupt/trap entry sequencer. It scans the requests,
// ranks them against the traps, runs the entry sequence and registers the
// one-cycle side pulses (acknowledge, error mask, resume, fetch permission).
// Assumes the inputs are stable around the clock edge and the trap flags
// are valid together with insn_boundary.
module irq_trap_seq
    import irq_seq_pkg::*;
#(
    parameter int NLEV = 8,
    parameter int DW   = 16,
    localparam int LW  = $clog2(NLEV)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   insn_boundary,
    input  logic                   cpu_waiting,
    input  logic [LW-1:0]          psw_pri,
    input  logic [DW-1:0]          pir_reg,
    input  logic [NLEV-1:1]        bus_irq_req,
    input  logic [(NLEV-1)*DW-1:0] bus_irq_vec,
    input  logic                   nxm_err,
    input  logic                   tmo_err,
    input  logic                   bad_opcode,
    input  logic [DW-1:0]          cur_pc,
    input  logic [DW-1:0]          cur_psw,
    input  logic [DW-1:0]          cur_sp,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [DW-1:0]          mem_addr,
    output logic [DW-1:0]          mem_wdata,
    input  logic [DW-1:0]          mem_rdata,
    input  logic                   mem_ack,
    output logic [NLEV-1:1]        bus_irq_ack,
    output logic [DW-1:0]          err_set,
    output logic                   resume,
    output logic                   fetch_go,
    output logic                   entry_done,
    output logic [DW-1:0]          new_pc,
    output logic [DW-1:0]          new_psw,
    output logic [DW-1:0]          new_sp
);
    logic            seq_idle, irq_hit, irq_from_bus, ev_take, fetch_ok;
    logic [LW-1:0]   irq_level;
    logic [DW-1:0]   irq_vec, ev_vec, err_d;
    logic [NLEV-1:1] ack_d;
    event_e          ev_kind;

    wire unused_pir_low = ^pir_reg[PIR_LEVEL_BASE:0];

    irq_level_scan #(.NLEV(NLEV), .DW(DW)) u_scan (
        .pri      (psw_pri),
        .sw_req   (pir_reg[PIR_LEVEL_BASE+NLEV-1:PIR_LEVEL_BASE+1]),
        .hw_req   (bus_irq_req),
        .hw_vec   (bus_irq_vec),
        .hit      (irq_hit),
        .from_bus (irq_from_bus),
        .level    (irq_level),
        .vector   (irq_vec)
    );

    trap_priority_pick #(.DW(DW)) u_pick (
        .idle         (seq_idle),
        .boundary     (insn_boundary),
        .waiting      (cpu_waiting),
        .nxm_err      (nxm_err),
        .tmo_err      (tmo_err),
        .bad_opcode   (bad_opcode),
        .irq_hit      (irq_hit),
        .irq_from_bus (irq_from_bus),
        .irq_vec      (irq_vec),
        .kind         (ev_kind),
        .vector       (ev_vec),
        .take         (ev_take),
        .fetch_ok     (fetch_ok)
    );

    vector_entry_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ev_take),
        .vec       (ev_vec),
        .cur_pc    (cur_pc),
        .cur_psw   (cur_psw),
        .cur_sp    (cur_sp),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .idle      (seq_idle),
        .done      (entry_done),
        .new_pc    (new_pc),
        .new_psw   (new_psw),
        .new_sp    (new_sp)
    );

    // Acknowledge decode, one bit per bus level.
    for (genvar l = 1; l < NLEV; l++) begin : g_ack
        assign ack_d[l] = (ev_kind == EV_BUS_IRQ) && (irq_level == LW'(l));
    end

    // Error-register set mask for a bus-fault trap.
    always_comb begin
        err_d              = '0;
        err_d[ERR_NXM_POS] = (ev_kind == EV_BUS_FAULT) && nxm_err;
        err_d[ERR_TMO_POS] = (ev_kind == EV_BUS_FAULT) && tmo_err;
    end

    // Register the single-cycle side pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_irq_ack <= '0;
            err_set     <= '0;
            resume      <= 1'b0;
            fetch_go    <= 1'b0;
        end else begin
            bus_irq_ack <= ack_d;
            err_set     <= err_d;
            resume      <= ev_take && cpu_waiting;
            fetch_go    <= fetch_ok;
        end
    end
endmodule

// File: rtl/irq_trap_seq_chk.sv
// Protocol and priority checks for irq_trap_seq, attached by bind.
module irq_trap_seq_chk #(
    parameter int NLEV = 8,
    parameter int DW   = 16,
    localparam int LW  = $clog2(NLEV)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [LW-1:0]   psw_pri,
    input logic            cpu_waiting,
    input logic            nxm_err,
    input logic            tmo_err,
    input logic            mem_req,
    input logic            mem_we,
    input logic [DW-1:0]   mem_addr,
    input logic [DW-1:0]   mem_wdata,
    input logic            mem_ack,
    input logic [NLEV-1:1] bus_irq_ack,
    input logic [DW-1:0]   err_set,
    input logic            resume,
    input logic            fetch_go,
    input logic            entry_done
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_req && !entry_done && !resume && !fetch_go); // R1

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata)); // R10

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_irq_ack)); // R4

    for (genvar l = 1; l < NLEV; l++) begin : g_pri
        AST_ACK_ABOVE_PRI: assert property (@(posedge clk) disable iff (!rst_n)
            bus_irq_ack[l] |-> ($past(psw_pri) < LW'(l))); // R2
    end

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_set) |-> $past(nxm_err || tmo_err)); // R6

    AST_RESUME_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> $past(cpu_waiting)); // R8

    AST_FETCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |-> !mem_req && !entry_done); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |=> !entry_done); // R9
endmodule

bind irq_trap_seq irq_trap_seq_chk #(.NLEV(NLEV), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .psw_pri     (psw_pri),
    .cpu_waiting (cpu_waiting),
    .nxm_err     (nxm_err),
    .tmo_err     (tmo_err),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .bus_irq_ack (bus_irq_ack),
    .err_set     (err_set),
    .resume      (resume),
    .fetch_go    (fetch_go),
    .entry_done  (entry_done)
);

// File: tb/irq_trap_seq_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected accesses and results.
// A memory responder/monitor pops and compares them as they complete.
module irq_trap_seq_test;
    localparam int NLEV = 8;
    localparam int DW   = 16;
    localparam int MEM_LAT = 2;
    localparam logic [15:0] OLD_PC  = 16'h0B26;
    localparam logic [15:0] OLD_PSW = 16'h00E5;
    localparam logic [15:0] OLD_SP  = 16'h01F0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic insn_boundary = 1'b0, cpu_waiting = 1'b0;
    logic [2:0] psw_pri = '0;
    logic [15:0] pir_reg = '0;
    logic [NLEV-1:1] bus_irq_req = '0;
    logic [(NLEV-1)*DW-1:0] bus_irq_vec;
    logic nxm_err = 1'b0, tmo_err = 1'b0, bad_opcode = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic mem_ack = 1'b0;
    logic mem_req, mem_we, resume, fetch_go, entry_done;
    logic [15:0] mem_addr, mem_wdata, err_set, new_pc, new_psw, new_sp;
    logic [NLEV-1:1] bus_irq_ack;

    typedef struct { int kind; logic [15:0] addr; logic [15:0] data; } item_t;
    item_t exp_q[$];
    int n_vec = 0;
    int n_bad = 0;
    string cur_tag = "R1";
    logic [15:0] mem [0:255];

    always #2 clk = ~clk;

    irq_trap_seq #(.NLEV(NLEV), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary),
        .cpu_waiting(cpu_waiting), .psw_pri(psw_pri), .pir_reg(pir_reg),
        .bus_irq_req(bus_irq_req), .bus_irq_vec(bus_irq_vec),
        .nxm_err(nxm_err), .tmo_err(tmo_err), .bad_opcode(bad_opcode),
        .cur_pc(OLD_PC), .cur_psw(OLD_PSW), .cur_sp(OLD_SP),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .bus_irq_ack(bus_irq_ack), .err_set(err_set), .resume(resume),
        .fetch_go(fetch_go), .entry_done(entry_done), .new_pc(new_pc),
        .new_psw(new_psw), .new_sp(new_sp)
    );

    function automatic logic [15:0] bvec(input int l);
        return 16'h0040 + 16'(4 * l);
    endfunction

    function automatic logic [NLEV-1:1] ackbit(input int l);
        return (NLEV-1)'(1) << (l - 1);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Queue the four accesses and the result of one vectored entry (R5).
    task automatic push_entry(input logic [15:0] v);
        exp_q.push_back('{0, v + 16'd2, 16'h0});
        exp_q.push_back('{1, OLD_SP - 16'd2, OLD_PSW});
        exp_q.push_back('{1, OLD_SP - 16'd4, OLD_PC});
        exp_q.push_back('{0, v, 16'h0});
        exp_q.push_back('{2, v, 16'h0});
    endtask

    task automatic step(output logic [NLEV-1:1] ack, output logic [15:0] err,
                        output logic res, output logic fg);
        @(negedge clk); insn_boundary = 1'b1;
        @(negedge clk); insn_boundary = 1'b0;
        ack = bus_irq_ack; err = err_set; res = resume; fg = fetch_go;
    endtask

    task automatic drain();
        for (int i = 0; i < 80 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(cur_tag, "expected items left", exp_q.size(), 0);
    endtask

    // Memory responder and scoreboard monitor.
    initial begin
        int lat = 0;
        logic [15:0] s_addr, s_wdata;
        logic s_we;
        item_t it;
        forever begin
            @(negedge clk);
            if (!rst_n || mem_ack) begin
                mem_ack = 1'b0;
                lat = 0;
            end else if (mem_req) begin
                if (lat == 0) begin s_addr = mem_addr; s_we = mem_we; s_wdata = mem_wdata; end
                if (lat == MEM_LAT) begin
                    mem_ack = 1'b1;
                    mem_rdata = mem[mem_addr[8:1]];
                    chk("R10", "request held", {s_we, s_addr, s_wdata[14:0]},
                        {mem_we, mem_addr, mem_wdata[14:0]});
                    if (exp_q.size() == 0 || exp_q[0].kind == 2) begin
                        n_vec++; n_bad++;
                        $display("FAIL %s access: actual %0h expected none", cur_tag, mem_addr);
                    end else begin
                        it = exp_q.pop_front();
                        chk("R5", "access kind", {31'd0, mem_we}, it.kind);
                        chk("R5", "access address", mem_addr, it.addr);
                        if (it.kind == 1) chk("R5", "write data", mem_wdata, it.data);
                    end
                end else lat++;
            end
            if (entry_done) begin
                if (exp_q.size() == 0 || exp_q[0].kind != 2) begin
                    n_vec++; n_bad++;
                    $display("FAIL %s entry_done: actual 1 expected 0", cur_tag);
                end else begin
                    it = exp_q.pop_front();
                    chk(cur_tag, "new_pc", new_pc, 16'h4000 | it.addr);
                    chk("R5", "new_psw", new_psw, 16'h2000 | it.addr);
                    chk("R5", "new_sp", new_sp, OLD_SP - 16'd4);
                end
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL R9 watchdog: actual hung expected completion");
        summary();
    end

    initial begin
        logic [NLEV-1:1] ack;
        logic [15:0] err;
        logic res, fg;
        for (int i = 0; i < 256; i++)
            mem[i] = ((2 * i) % 4 == 0) ? (16'h4000 | 16'(2 * i)) : (16'h2000 | 16'(2 * i - 2));
        for (int l = 1; l < NLEV; l++) bus_irq_vec[(l-1)*DW +: DW] = bvec(l);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "quiet after reset", {mem_req, entry_done, resume, fetch_go}, 0);
        chk("R1", "ack and err after reset", {bus_irq_ack, err_set}, 0);

        cur_tag = "R9";
        step(ack, err, res, fg);
        chk("R9", "fetch_go with nothing pending", fg, 1);
        drain();

        cur_tag = "R2";
        pir_reg = 16'h1 << 11; psw_pri = 3'd4;
        step(ack, err, res, fg);
        chk("R2", "level 3 below pri 4 not taken", fg, 1);
        psw_pri = 3'd3;
        step(ack, err, res, fg);
        chk("R2", "level equal to pri not taken", fg, 1);
        drain();
        cur_tag = "R3";
        psw_pri = 3'd2; push_entry(16'h00A0);
        step(ack, err, res, fg);
        chk("R3", "software grant has no ack, no fetch", {ack, fg}, 0);
        drain();
        cur_tag = "R9";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9", "no new entry without boundary", mem_req, 0);
        end
        pir_reg = '0;

        cur_tag = "R4";
        psw_pri = 3'd0; pir_reg = 16'h1 << 12; bus_irq_req[5] = 1'b1;
        push_entry(bvec(5));
        step(ack, err, res, fg);
        chk("R4", "bus level 5 over software level 4", ack, ackbit(5));
        bus_irq_req[5] = 1'b0;
        drain();
        cur_tag = "R3";
        push_entry(16'h00A0);
        step(ack, err, res, fg);
        chk("R3", "software level 4 next", ack, 0);
        drain();
        pir_reg = '0;

        cur_tag = "R3";
        pir_reg = 16'h1 << 14; bus_irq_req[6] = 1'b1;
        push_entry(16'h00A0);
        step(ack, err, res, fg);
        chk("R3", "software wins within level 6", ack, 0);
        drain();
        pir_reg = '0;
        cur_tag = "R4";
        push_entry(bvec(6));
        step(ack, err, res, fg);
        chk("R4", "bus level 6 after software", ack, ackbit(6));
        bus_irq_req[6] = 1'b0;
        drain();

        cur_tag = "R2";
        psw_pri = 3'd2; bus_irq_req[7] = 1'b1; bus_irq_req[3] = 1'b1;
        push_entry(bvec(7));
        step(ack, err, res, fg);
        chk("R2", "level 7 before level 3", ack, ackbit(7));
        bus_irq_req[7] = 1'b0;
        drain();
        push_entry(bvec(3));
        step(ack, err, res, fg);
        chk("R2", "level 3 granted next", ack, ackbit(3));
        bus_irq_req[3] = 1'b0;
        drain();

        cur_tag = "R6";
        psw_pri = 3'd0; pir_reg = 16'h1 << 15; nxm_err = 1'b1;
        push_entry(16'h0004);
        step(ack, err, res, fg);
        chk("R6", "nxm error mask", err, 16'h0020);
        nxm_err = 1'b0;
        drain();
        tmo_err = 1'b1;
        push_entry(16'h0004);
        step(ack, err, res, fg);
        chk("R6", "timeout error mask", err, 16'h0010);
        drain();
        nxm_err = 1'b1; bad_opcode = 1'b1;
        push_entry(16'h0004);
        step(ack, err, res, fg);
        chk("R6", "both faults over illegal opcode", err, 16'h0030);
        nxm_err = 1'b0; tmo_err = 1'b0;
        drain();
        cur_tag = "R7";
        bus_irq_req[7] = 1'b1;
        push_entry(16'h0010);
        step(ack, err, res, fg);
        chk("R7", "illegal opcode over interrupts", {ack, err}, 0);
        bad_opcode = 1'b0; pir_reg = '0;
        drain();
        cur_tag = "R4";
        push_entry(bvec(7));
        step(ack, err, res, fg);
        chk("R4", "bus level 7 after trap", ack, ackbit(7));
        bus_irq_req[7] = 1'b0;
        drain();

        cur_tag = "R8";
        psw_pri = 3'd1;
        @(negedge clk); cpu_waiting = 1'b1; bad_opcode = 1'b1; nxm_err = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R8", "idle wait: no access, fetch, error", {mem_req, fetch_go, resume, err_set}, 0);
        end
        push_entry(bvec(2));
        bus_irq_req[2] = 1'b1;
        @(negedge clk);
        chk("R8", "resume and ack on wake", {resume, bus_irq_ack}, {1'b1, ackbit(2)});
        cpu_waiting = 1'b0; bus_irq_req[2] = 1'b0; bad_opcode = 1'b0; nxm_err = 1'b0;
        drain();

        cur_tag = "R2";
        psw_pri = 3'd7; pir_reg = 16'hFE00; bus_irq_req = '1;
        step(ack, err, res, fg);
        chk("R2", "all masked at priority 7", {ack, fg}, 1);
        drain();

        summary();
    end
endmodule